// File: doc/BRIEF.md
# Dual-Master Channel Arbitration Controller

This block decides which of two upstream bus masters is connected to a single shared downstream bus. Each master asks for the bus with a takeover request strobe. The block then drives one switch-enable line per channel, so that at most one channel is connected at any time. Either master can take the bus whenever it wants. A master that has failed or been removed can therefore be shut out by the other one.

A takeover can optionally wait for an external recovery sequencer. In that case both channels are disconnected while the sequencer runs, and the switch completes when the sequencer reports done. Each master has its own configuration word, its own sticky status bits and its own active-low interrupt output. The status bits record three causes: a downstream interrupt, loss of control, and completed recovery. Each cause can be masked separately at the output. The register decoder is modelled as plain write and clear strobes. A parameter picks the owner after reset: either channel 0 connected, or nothing connected.

Top module: `master_select_ctrl`

## Requirements
- R1: `sw_en` never has more than one bit set. Bit 0 connects channel 0 and bit 1 connects channel 1.
- R2: After reset, `sw_en` is 2'b01 when `BOOT_CH0`=1 and 2'b00 when `BOOT_CH0`=0.
- R3: Suppose recovery is off for the requester (bit 3 of its configuration word is 0). A request from the master that does not own the bus then moves ownership to it, and `sw_en` shows the change right after the clock edge that samples the request. A request from the current owner changes nothing.
- R4: When both request lines are high in the same cycle, a current owner keeps the bus. If nobody owns it, channel 0 wins.
- R5: If the requester has bit 3 of its configuration set, the takeover goes pending instead. `sw_en` becomes 2'b00 and `rec_start` pulses for one cycle. Ownership passes to the requester at the edge that samples `rec_done`. Requests made while a takeover is pending are ignored and do not pulse `rec_start` again.
- R6: On every change of ownership, status bit 1 of the master that lost the bus is set, one cycle after `sw_en` changes.
- R7: When a switch completes after recovery, status bit 2 of the new owner is set.
- R8: While `irq_in_n` is low, status bit 0 of both masters is set.
- R9: `irq_n[m]` is low exactly when master m has a status bit set whose cause is enabled. Bit 0 counts only when configuration bit 0 (forward) is 1. Bit 1 counts only when configuration bit 1 (mask loss) is 0. Bit 2 counts only when configuration bit 2 (mask recovery) is 0.
- R10: `clr[m]` clears only master m's status bits. A cause that sets a bit in the same cycle wins over the clear.
- R11: While `rst_n` is low, ownership returns to the `BOOT_CH0` default, any pending takeover is dropped, and all status bits and configuration words are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 2 | Takeover request strobe, one bit per master |
| cfg_we | input | 2 | Configuration write strobe, one bit per master |
| cfg0_wdata | input | CFG_W | Configuration word written by master 0 |
| cfg1_wdata | input | CFG_W | Configuration word written by master 1 |
| clr | input | 2 | Status clear strobe, one bit per master |
| irq_in_n | input | 1 | Downstream interrupt, active low |
| rec_done | input | 1 | Recovery sequencer finished |
| rec_start | output | 1 | One-cycle pulse that starts the recovery sequencer |
| sw_en | output | 2 | Channel switch enables |
| sts0 | output | 3 | Sticky status of master 0 |
| sts1 | output | 3 | Sticky status of master 1 |
| irq_n | output | 2 | Active-low interrupt toward each master |

## Verification
The assertions assume that `rec_done` is raised only while a takeover is pending. They also assume that every strobe is a synchronous, single-cycle level sampled on the rising edge. The stimulus drives all inputs on the falling edge. It pulses `rec_done` only after a pending takeover has been seen at `sw_en` as 2'b00. It holds `irq_in_n` high except inside the forwarding and reset tests.

// File: rtl/msel_pkg.sv
package msel_pkg;
   localparam int STS_W    = 3;
   // configuration word fields
   localparam int CFG_FWD  = 0;
   localparam int CFG_LMSK = 1;
   localparam int CFG_DMSK = 2;
   localparam int CFG_REC  = 3;
   localparam int CFG_MIN  = 4;
   // status word fields
   localparam int STS_DN   = 0;
   localparam int STS_LOST = 1;
   localparam int STS_RDN  = 2;
endpackage

// File: rtl/msel_owner_fsm.sv
module msel_owner_fsm #(
   parameter bit BOOT_CH0 = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req,
   input  logic [1:0] rec_en,
   input  logic       rec_done,
   output logic [1:0] sw_en,
   output logic       rec_start,
   output logic [1:0] ev_lost,
   output logic [1:0] ev_rdone
);
   logic [1:0] rst_owner;
   generate
      if (BOOT_CH0) begin : g_boot_ch0
         assign rst_owner = 2'b01;
      end else begin : g_boot_none
         assign rst_owner = 2'b00;
      end
   endgenerate

   logic [1:0] owner_q, tgt_oh, pend_oh, ev_lost_q, ev_rdone_q;
   logic       pend_q, pend_ch_q, take, tgt, rec_start_q;

   always_comb begin
      take = 1'b0;
      tgt  = 1'b0;
      if (!pend_q) begin
         if (req == 2'b11) begin
            if (owner_q == 2'b00) begin
               take = 1'b1;
               tgt  = 1'b0;
            end
         end else if (req[0] && !owner_q[0]) begin
            take = 1'b1;
            tgt  = 1'b0;
         end else if (req[1] && !owner_q[1]) begin
            take = 1'b1;
            tgt  = 1'b1;
         end
      end
      tgt_oh  = tgt ? 2'b10 : 2'b01;
      pend_oh = pend_ch_q ? 2'b10 : 2'b01;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q     <= rst_owner;
         pend_q      <= 1'b0;
         pend_ch_q   <= 1'b0;
         rec_start_q <= 1'b0;
         ev_lost_q   <= 2'b00;
         ev_rdone_q  <= 2'b00;
      end else begin
         rec_start_q <= 1'b0;
         ev_lost_q   <= 2'b00;
         ev_rdone_q  <= 2'b00;
         if (pend_q && rec_done) begin
            owner_q    <= pend_oh;
            pend_q     <= 1'b0;
            ev_lost_q  <= owner_q & ~pend_oh;
            ev_rdone_q <= pend_oh;
         end else if (take) begin
            if (rec_en[tgt]) begin
               pend_q      <= 1'b1;
               pend_ch_q   <= tgt;
               rec_start_q <= 1'b1;
            end else begin
               owner_q   <= tgt_oh;
               ev_lost_q <= owner_q;
            end
         end
      end
   end

   assign sw_en     = pend_q ? 2'b00 : owner_q;
   assign rec_start = rec_start_q;
   assign ev_lost   = ev_lost_q;
   assign ev_rdone  = ev_rdone_q;

   a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_en));
   a_r4_owner_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (req == 2'b11 && owner_q != 2'b00 && !pend_q) |=> $stable(owner_q));
   a_r5_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !rec_done) |=> ($stable(owner_q) && pend_q));
   a_r5_single_start: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && $past(pend_q)) |-> !rec_start);
endmodule

// File: rtl/msel_irq_bank.sv
module msel_irq_bank
   import msel_pkg::*;
#(
   parameter int CFG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             clr,
   input  logic             ev_dn,
   input  logic             ev_lost,
   input  logic             ev_rdone,
   output logic [STS_W-1:0] sts,
   output logic             rec_en,
   output logic             irq_n
);
   logic [CFG_W-1:0] cfg_q;
   logic [STS_W-1:0] sts_q, set_v, unmask;

   always_comb begin
      set_v           = '0;
      set_v[STS_DN]   = ev_dn;
      set_v[STS_LOST] = ev_lost;
      set_v[STS_RDN]  = ev_rdone;
      unmask           = '0;
      unmask[STS_DN]   = cfg_q[CFG_FWD];
      unmask[STS_LOST] = ~cfg_q[CFG_LMSK];
      unmask[STS_RDN]  = ~cfg_q[CFG_DMSK];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         sts_q <= '0;
      end else begin
         if (cfg_we) cfg_q <= cfg_wdata;
         sts_q <= (clr ? '0 : sts_q) | set_v;
      end
   end

   assign sts    = sts_q;
   assign rec_en = cfg_q[CFG_REC];
   assign irq_n  = ~|(sts_q & unmask);

   a_r6_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ev_lost |=> sts[STS_LOST]);
   a_r7_rdone_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rdone |=> sts[STS_RDN]);
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ev_dn && !ev_lost && !ev_rdone) |=> (sts == '0));
   a_r9_out_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (sts != '0));
endmodule

// File: rtl/master_select_ctrl.sv
module master_select_ctrl
   import msel_pkg::*;
#(
   parameter bit BOOT_CH0 = 1'b1,
   parameter int CFG_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       req,
   input  logic [1:0]       cfg_we,
   input  logic [CFG_W-1:0] cfg0_wdata,
   input  logic [CFG_W-1:0] cfg1_wdata,
   input  logic [1:0]       clr,
   input  logic             irq_in_n,
   input  logic             rec_done,
   output logic             rec_start,
   output logic [1:0]       sw_en,
   output logic [STS_W-1:0] sts0,
   output logic [STS_W-1:0] sts1,
   output logic [1:0]       irq_n
);
   localparam int N_MST = 2;

   generate
      if (CFG_W < CFG_MIN) begin : g_bad_cfg_w
         $error("CFG_W too narrow for the configuration fields");
      end
   endgenerate

   logic [N_MST-1:0] rec_en, ev_lost, ev_rdone;
   logic [CFG_W-1:0] cfg_wd [N_MST];
   logic [STS_W-1:0] sts_a  [N_MST];

   assign cfg_wd[0] = cfg0_wdata;
   assign cfg_wd[1] = cfg1_wdata;

   msel_owner_fsm #(.BOOT_CH0(BOOT_CH0)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(req), .rec_en(rec_en),
      .rec_done(rec_done), .sw_en(sw_en), .rec_start(rec_start),
      .ev_lost(ev_lost), .ev_rdone(ev_rdone)
   );

   for (genvar m = 0; m < N_MST; m++) begin : g_mst
      msel_irq_bank #(.CFG_W(CFG_W)) u_bank (
         .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we[m]),
         .cfg_wdata(cfg_wd[m]), .clr(clr[m]), .ev_dn(~irq_in_n),
         .ev_lost(ev_lost[m]), .ev_rdone(ev_rdone[m]),
         .sts(sts_a[m]), .rec_en(rec_en[m]), .irq_n(irq_n[m])
      );
   end

   assign sts0 = sts_a[0];
   assign sts1 = sts_a[1];
endmodule

// File: tb/test_master_select_ctrl.sv
`timescale 1ns/1ps
module test_master_select_ctrl;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0, irq_in_n = 1'b1, rec_done = 1'b0;
   logic [1:0] req = 2'b00, cfg_we = 2'b00, clr = 2'b00;
   logic [3:0] cfg0_wdata = 4'h0, cfg1_wdata = 4'h0;
   logic       rec_start, rec_start_b;
   logic [1:0] sw_en, irq_n, sw_en_b, irq_n_b;
   logic [2:0] sts0, sts1, sts0_b, sts1_b;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   master_select_ctrl #(.BOOT_CH0(1'b1)) i_master_select_ctrl (
      .clk(clk), .rst_n(rst_n), .req(req), .cfg_we(cfg_we),
      .cfg0_wdata(cfg0_wdata), .cfg1_wdata(cfg1_wdata), .clr(clr),
      .irq_in_n(irq_in_n), .rec_done(rec_done), .rec_start(rec_start),
      .sw_en(sw_en), .sts0(sts0), .sts1(sts1), .irq_n(irq_n));

   master_select_ctrl #(.BOOT_CH0(1'b0)) i_master_select_ctrl_none (
      .clk(clk), .rst_n(rst_n), .req(req), .cfg_we(cfg_we),
      .cfg0_wdata(cfg0_wdata), .cfg1_wdata(cfg1_wdata), .clr(clr),
      .irq_in_n(irq_in_n), .rec_done(rec_done), .rec_start(rec_start_b),
      .sw_en(sw_en_b), .sts0(sts0_b), .sts1(sts1_b), .irq_n(irq_n_b));

   // each entry: {req[1:0], expected sw_en[1:0]}, recovery off
   localparam logic [3:0] VEC [0:6] = '{
      4'b11_01, 4'b10_10, 4'b11_10, 4'b01_01, 4'b00_01, 4'b01_01, 4'b10_10 };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_req(input logic [1:0] v);
      @(negedge clk) req = v;
      @(negedge clk) req = 2'b00;
      cyc(2);
   endtask

   task automatic wr_cfg(input logic [1:0] we, input logic [3:0] d0, input logic [3:0] d1);
      @(negedge clk) begin cfg_we = we; cfg0_wdata = d0; cfg1_wdata = d1; end
      @(negedge clk) cfg_we = 2'b00;
   endtask

   task automatic do_clr(input logic [1:0] c);
      @(negedge clk) clr = c;
      @(negedge clk) clr = 2'b00;
   endtask

   initial begin
      cyc(3);
      // R2 reset state of both variants
      chk("R2 sw_en boot ch0", 8'(sw_en), 8'h1);
      chk("R2 sw_en boot none", 8'(sw_en_b), 8'h0);
      chk("R11 irq_n idle", 8'(irq_n), 8'h3);
      @(negedge clk) rst_n = 1'b1;
      cyc(2);
      chk("R11 status zero", {2'b0, sts1, sts0}, 8'h0);

      for (int k = 0; k < 7; k++) begin
         do_req(VEC[k][3:2]);
         chk($sformatf("R3 R4 vector %0d sw_en", k), 8'(sw_en), 8'(VEC[k][1:0]));
         if (k == 0) chk("R4 no owner both request -> ch0", 8'(sw_en_b), 8'h1);
         chk("R1 onehot", 8'($countones(sw_en) <= 1), 8'h1);
      end

      // R6 both masters lost control during table; unmasked -> both irq low
      chk("R6 lost bits", {2'b0, sts1, sts0}, {2'b0, 3'b010, 3'b010});
      chk("R9 both irq low", 8'(irq_n), 8'h0);
      do_clr(2'b01);
      chk("R10 clear only master0", {2'b0, sts1, sts0}, {2'b0, 3'b010, 3'b000});
      chk("R10 irq after clr0", 8'(irq_n), 8'h1);
      do_clr(2'b10);
      chk("R10 clear master1", 8'(irq_n), 8'h3);

      // R9 mask loss interrupt of master 0 (owner now ch1)
      wr_cfg(2'b01, 4'b0010, 4'b0000);
      do_req(2'b01);
      chk("R6 ch1 lost", 8'(sts1), 8'h2);
      chk("R9 ch1 irq low", 8'(irq_n), 8'h1);
      do_req(2'b10);
      chk("R6 ch0 lost while masked", 8'(sts0), 8'h2);
      chk("R9 masked cause silent", 8'(irq_n[0]), 8'h1);
      do_clr(2'b11);

      // R8 forwarding enabled on master 0 only
      wr_cfg(2'b11, 4'b0011, 4'b0000);
      @(negedge clk) irq_in_n = 1'b0;
      cyc(2);
      chk("R8 status bit0 both", {2'b0, sts1, sts0}, {2'b0, 3'b001, 3'b001});
      chk("R8 R9 forward only to master0", 8'(irq_n), 8'h2);
      @(negedge clk) irq_in_n = 1'b1;
      do_clr(2'b11);
      chk("R10 cleared after forward", {2'b0, sts1, sts0}, 8'h0);

      // R5 R7 recovery takeover by master 0 (owner is ch1)
      wr_cfg(2'b01, 4'b1000, 4'b0000);
      @(negedge clk) req = 2'b01;
      @(negedge clk) req = 2'b00;
      chk("R5 rec_start pulse", 8'(rec_start), 8'h1);
      chk("R5 disconnected while pending", 8'(sw_en), 8'h0);
      @(negedge clk);
      chk("R5 rec_start single cycle", 8'(rec_start), 8'h0);
      @(negedge clk) req = 2'b01;
      @(negedge clk) req = 2'b00;
      chk("R5 request ignored while pending", 8'(rec_start), 8'h0);
      cyc(3);
      chk("R5 still pending", 8'(sw_en), 8'h0);
      @(negedge clk) rec_done = 1'b1;
      @(negedge clk) rec_done = 1'b0;
      chk("R5 switch on done", 8'(sw_en), 8'h1);
      @(negedge clk);
      chk("R7 recovery done bit", 8'(sts0), 8'h4);
      chk("R6 ch1 lost after recovery", 8'(sts1), 8'h2);
      chk("R7 R9 irq both low", 8'(irq_n), 8'h0);

      // R11 reset restores defaults, including configuration
      wr_cfg(2'b10, 4'b0001, 4'b0001);
      do_req(2'b10);
      @(negedge clk) rst_n = 1'b0;
      cyc(2);
      chk("R11 owner default", 8'(sw_en), 8'h1);
      chk("R11 owner default none", 8'(sw_en_b), 8'h0);
      chk("R11 status cleared", {2'b0, sts1, sts0}, 8'h0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk) irq_in_n = 1'b0;
      cyc(2);
      chk("R11 forwarding disabled after reset", 8'(irq_n), 8'h3);
      @(negedge clk) irq_in_n = 1'b1;

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      cyc(20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule